// File: doc/BRIEF.md
# USB Transceiver Receive-Status Reporter

This block sits on the transceiver side of a ULPI link. It watches the line state, an encoded VBUS state, an encoded receive-event code, the ID pin level and the BVALID session comparator. Whenever the status it would report differs from the last status it sent, it takes the bus by raising DIR, waits out a turnaround, drives one receive-command byte on the data bus with NXT low, then releases DIR and waits out a second turnaround.

Edges of BVALID can be flagged to the link through an alternate-interrupt bit in the byte. Each edge direction has its own enable bit from a power-control register. While the low-power flag is set, nothing is reported. When low power ends, a report is sent only if a difference or an enabled BVALID edge still stands. A condition that appeared and went away during low power produces no byte. Changes that arrive while a byte is on the bus are folded into one immediate follow-on byte carrying the latest values.

The VBUS and event encodings are computed upstream and arrive as 2-bit codes. Packet receive data is handled elsewhere.

Top module: `ulpi_status_reporter`

## Requirements
- R1: After reset, dir_o, nxt_o and data_o are all 0. The reference status (all fields zero, BVALID low) counts as already sent.
- R2: A reported byte has line state in bits [1:0], VBUS code in [3:2], event code in [5:4], the ID level in bit 6 and the alternate-interrupt flag in bit 7.
- R3: A status difference seen in idle raises dir_o at the next clock. dir_o then stays high with data_o at 0 for TURN_CYC cycles, followed by one cycle with the byte on data_o.
- R4: After the last byte, dir_o drops and stays low for TURN_CYC cycles, with data_o at 0, before it can rise again, even if status changes during that gap.
- R5: While status equals the last status sent and no enabled BVALID edge stands, dir_o stays low.
- R6: If status changes while a byte is on the bus, the next cycle carries a second byte with the latest values and no turnaround between them. Values that change and are overwritten before capture are never sent.
- R7: A BVALID rise since the last report, with the rise enable set, triggers a report with bit 7 set. With the enable clear, the rise causes no report.
- R8: A BVALID fall since the last report, with the fall enable set, triggers a report with bit 7 set. With the enable clear, the fall causes no report.
- R9: Bit 7 is clear in the next byte unless a new enabled BVALID edge has occurred since the previous byte.
- R10: While low_power_i is high, no report starts. On exit, a report is sent only if status still differs or an enabled BVALID edge still stands. A condition removed before exit sends nothing.
- R11: nxt_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_state_i | input | 2 | Current line state |
| vbus_code_i | input | 2 | Encoded VBUS state |
| event_code_i | input | 2 | Encoded receive event |
| id_level_i | input | 1 | ID pin level |
| bvalid_i | input | 1 | Session-valid comparator output |
| bvalid_rise_en_i | input | 1 | Flag BVALID rising edges in bit 7 |
| bvalid_fall_en_i | input | 1 | Flag BVALID falling edges in bit 7 |
| low_power_i | input | 1 | Low-power / serial mode active |
| dir_o | output | 1 | Bus direction, high while the block owns the bus |
| nxt_o | output | 1 | Next strobe, held low for status bytes |
| data_o | output | 8 | Data bus |

## Verification
The bench builds the block with TURN_CYC = 2. This makes both turnaround counters count through more than one state, so an off-by-one in either window shows up as a shifted byte or a shortened gap. It also leaves a turnaround cycle in which inputs can be changed twice before capture, which is what the coalescing case in R6 needs. With this value the gap after DIR drops is long enough to inject a status change into it and confirm that DIR stays low for the full window.

// File: rtl/ulpi_rpt_pkg.sv
package ulpi_rpt_pkg;

    // Receive-command byte; bit positions are decoded by the link.
    typedef struct packed {
        logic       alt;
        logic       id;
        logic [1:0] evt;
        logic [1:0] vbus;
        logic [1:0] line;
    } rxcmd_t;

    localparam int STATUS_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TURN_UP = 2'd1,
        ST_SEND    = 2'd2,
        ST_TURN_DN = 2'd3
    } seq_state_e;

endpackage

// File: rtl/ulpi_rxcmd_track.sv
module ulpi_rxcmd_track
    import ulpi_rpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_i,
    input  logic [1:0] vbus_i,
    input  logic [1:0] evt_i,
    input  logic       id_i,
    input  logic       bvalid_i,
    input  logic       rise_en_i,
    input  logic       fall_en_i,
    input  logic       low_power_i,
    input  logic       capture_i,
    output rxcmd_t     cur_o,
    output logic       req_o
);

    typedef struct packed {
        logic [STATUS_W-1:0] sent;
        logic                bv_ref;
    } track_t;

    track_t r_q, r_d;
    logic   rise_seen, fall_seen, alt_now;
    rxcmd_t cur;

    always_comb begin
        rise_seen = bvalid_i & ~r_q.bv_ref;
        fall_seen = ~bvalid_i & r_q.bv_ref;
        alt_now   = (rise_seen & rise_en_i) | (fall_seen & fall_en_i);

        cur.alt  = alt_now;
        cur.id   = id_i;
        cur.evt  = evt_i;
        cur.vbus = vbus_i;
        cur.line = line_i;

        req_o = alt_now | (cur[STATUS_W-1:0] != r_q.sent);
        cur_o = cur;

        r_d = r_q;
        if (capture_i) begin
            r_d.sent   = cur[STATUS_W-1:0];
            r_d.bv_ref = bvalid_i;
        end else if (!alt_now && !low_power_i) begin
            // A disabled edge is absorbed so it cannot fire later.
            r_d.bv_ref = bvalid_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/ulpi_rxcmd_seq.sv
module ulpi_rxcmd_seq
    import ulpi_rpt_pkg::*;
#(
    parameter int TURN_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       low_power_i,
    input  rxcmd_t     cur_i,
    output logic       capture_o,
    output logic       dir_o,
    output logic [7:0] data_o
);

    localparam int CNT_W = (TURN_CYC < 2) ? 1 : $clog2(TURN_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TURN_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        rxcmd_t           held;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        capture_o = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i && !low_power_i) begin
                    r_d.st  = ST_TURN_UP;
                    r_d.cnt = '0;
                end
            end
            ST_TURN_UP: begin
                if (r_q.cnt == LAST) begin
                    r_d.st    = ST_SEND;
                    r_d.held  = cur_i;
                    capture_o = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_SEND: begin
                if (req_i) begin
                    r_d.held  = cur_i;
                    capture_o = 1'b1;
                end else begin
                    r_d.st  = ST_TURN_DN;
                    r_d.cnt = '0;
                end
            end
            ST_TURN_DN: begin
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dir_o  = (r_q.st == ST_TURN_UP) || (r_q.st == ST_SEND);
    assign data_o = (r_q.st == ST_SEND) ? r_q.held : 8'h00;

endmodule

// File: rtl/ulpi_status_reporter.sv
module ulpi_status_reporter
    import ulpi_rpt_pkg::*;
#(
    parameter int TURN_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state_i,
    input  logic [1:0] vbus_code_i,
    input  logic [1:0] event_code_i,
    input  logic       id_level_i,
    input  logic       bvalid_i,
    input  logic       bvalid_rise_en_i,
    input  logic       bvalid_fall_en_i,
    input  logic       low_power_i,
    output logic       dir_o,
    output logic       nxt_o,
    output logic [7:0] data_o
);

    rxcmd_t cur;
    logic   req, capture;

    ulpi_rxcmd_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_state_i),
        .vbus_i     (vbus_code_i),
        .evt_i      (event_code_i),
        .id_i       (id_level_i),
        .bvalid_i   (bvalid_i),
        .rise_en_i  (bvalid_rise_en_i),
        .fall_en_i  (bvalid_fall_en_i),
        .low_power_i(low_power_i),
        .capture_i  (capture),
        .cur_o      (cur),
        .req_o      (req)
    );

    ulpi_rxcmd_seq #(.TURN_CYC(TURN_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .low_power_i(low_power_i),
        .cur_i      (cur),
        .capture_o  (capture),
        .dir_o      (dir_o),
        .data_o     (data_o)
    );

    // Status bytes never carry packet data, so NXT stays low.
    assign nxt_o = 1'b0;

endmodule

// File: rtl/ulpi_status_reporter_chk.sv
module ulpi_status_reporter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       low_power_i,
    input logic       bvalid_rise_en_i,
    input logic       bvalid_fall_en_i,
    input logic       dir_o,
    input logic       nxt_o,
    input logic [7:0] data_o
);

    p_nxt_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_o == 1'b0);

    p_no_data_without_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_o |-> data_o == 8'h00);

    p_turn_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_o) |-> data_o == 8'h00);

    p_gap_after_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir_o) |=> !dir_o);

    p_quiet_in_low_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power_i && !dir_o) |=> !dir_o);

    p_alt_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_o[7] |-> $past(bvalid_rise_en_i || bvalid_fall_en_i));

endmodule

bind ulpi_status_reporter ulpi_status_reporter_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .low_power_i     (low_power_i),
    .bvalid_rise_en_i(bvalid_rise_en_i),
    .bvalid_fall_en_i(bvalid_fall_en_i),
    .dir_o           (dir_o),
    .nxt_o           (nxt_o),
    .data_o          (data_o)
);

// File: tb/ulpi_status_reporter_test.sv
module ulpi_status_reporter_test;

    localparam int T = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line = '0, vbus = '0, evt = '0;
    logic       id = 1'b0, bvalid = 1'b0, rise_en = 1'b0, fall_en = 1'b0, lp = 1'b0;
    logic       dir, nxt;
    logic [7:0] data;

    int n_run = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    ulpi_status_reporter #(.TURN_CYC(T)) uut (
        .clk(clk), .rst_n(rst_n),
        .line_state_i(line), .vbus_code_i(vbus), .event_code_i(evt),
        .id_level_i(id), .bvalid_i(bvalid),
        .bvalid_rise_en_i(rise_en), .bvalid_fall_en_i(fall_en),
        .low_power_i(lp), .dir_o(dir), .nxt_o(nxt), .data_o(data)
    );

    // Stimulus {line, vbus, evt, id} and expected byte (bit 7 clear).
    localparam logic [14:0] VEC [6] = '{
        {2'd1, 2'd0, 2'd0, 1'b0, 8'h01},
        {2'd2, 2'd3, 2'd0, 1'b0, 8'h0E},
        {2'd2, 2'd3, 2'd1, 1'b0, 8'h1E},
        {2'd0, 2'd0, 2'd2, 1'b1, 8'h60},
        {2'd3, 2'd1, 2'd3, 1'b1, 8'h77},
        {2'd0, 2'd2, 2'd0, 1'b0, 8'h08}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic sample(input logic d, input logic [7:0] v, input string tag);
        check({tag, " dir"}, int'(dir), int'(d));
        check({tag, " data"}, int'(data), int'(v));
        check("R11 nxt", int'(nxt), 0);
    endtask

    task automatic idle_for(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample(1'b0, 8'h00, tag);
        end
    endtask

    task automatic do_report(input logic [7:0] exp, input string tag);
        for (int i = 0; i < T; i++) begin
            @(negedge clk);
            sample(1'b1, 8'h00, {tag, " R3 turnaround"});
        end
        @(negedge clk);
        sample(1'b1, exp, {tag, " R2 byte"});
        @(negedge clk);
        sample(1'b0, 8'h00, {tag, " R4 drop"});
        idle_for(T, {tag, " R4 gap"});
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        sample(1'b0, 8'h00, "R1 in reset");
        rst_n = 1'b1;
        idle_for(4, "R1 R5 quiet after reset");

        // R2 R3 R4: table walk
        for (int k = 0; k < 6; k++) begin
            {line, vbus, evt, id} = VEC[k][14:8];
            do_report(VEC[k][7:0], $sformatf("R2 vec%0d", k));
        end
        idle_for(5, "R5 no change");

        // R6 back-to-back
        line = 2'd1;
        for (int i = 0; i < T; i++) begin
            @(negedge clk);
            sample(1'b1, 8'h00, "R6 turnaround");
        end
        @(negedge clk);
        sample(1'b1, 8'h09, "R6 first byte");
        line = 2'd2;
        @(negedge clk);
        sample(1'b1, 8'h0A, "R6 second byte");
        @(negedge clk);
        sample(1'b0, 8'h00, "R6 drop");
        idle_for(T, "R6 gap");

        // R6 coalescing during turnaround
        line = 2'd3;
        @(negedge clk);
        sample(1'b1, 8'h00, "R6 coalesce turn");
        line = 2'd0; id = 1'b1;
        for (int i = 1; i < T; i++) begin
            @(negedge clk);
            sample(1'b1, 8'h00, "R6 coalesce turn");
        end
        @(negedge clk);
        sample(1'b1, 8'h48, "R6 latest only");
        @(negedge clk);
        sample(1'b0, 8'h00, "R6 single byte");
        idle_for(T, "R6 gap");

        // R4 change inside the gap
        line = 2'd1;
        for (int i = 0; i < T; i++) @(negedge clk);
        @(negedge clk);
        sample(1'b1, 8'h49, "R4 byte");
        @(negedge clk);
        sample(1'b0, 8'h00, "R4 drop");
        line = 2'd2;
        idle_for(T, "R4 held gap");
        do_report(8'h4A, "R4 after gap");

        // R7 R9 rise with enable, then alt clears
        rise_en = 1'b1; bvalid = 1'b1;
        do_report(8'hCA, "R7 rise");
        line = 2'd1;
        do_report(8'h49, "R9 alt cleared");

        // R8 fall with enable
        rise_en = 1'b0; fall_en = 1'b1; bvalid = 1'b0;
        do_report(8'hC9, "R8 fall");

        // R7 R8 disabled edges
        fall_en = 1'b0; bvalid = 1'b1;
        idle_for(6, "R7 disabled rise");
        bvalid = 1'b0;
        idle_for(6, "R8 disabled fall");
        rise_en = 1'b1;
        idle_for(6, "R7 stale edge");
        rise_en = 1'b0;

        // R10 low power
        lp = 1'b1; line = 2'd2;
        idle_for(6, "R10 held in low power");
        line = 2'd1;
        idle_for(4, "R10 reverted");
        lp = 1'b0;
        idle_for(6, "R10 removed line change");
        lp = 1'b1; rise_en = 1'b1; bvalid = 1'b1;
        idle_for(4, "R10 edge in low power");
        bvalid = 1'b0;
        idle_for(4, "R10 edge reverted");
        lp = 1'b0;
        idle_for(6, "R10 removed edge");
        lp = 1'b1; line = 2'd3;
        idle_for(4, "R10 standing change");
        lp = 1'b0;
        do_report(8'h4B, "R10 exit report");
        lp = 1'b1; bvalid = 1'b1;
        idle_for(4, "R10 standing edge");
        lp = 1'b0;
        do_report(8'hCB, "R10 exit alt");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule